// File: doc/BRIEF.md
# Manual Exposure Shutter Sequencer

This block walks an image sensor through one hand-controlled exposure and readout. The host starts it by writing action codes. It then drives three control lines: the substrate charge pulse (VSUB), the mechanical shutter (MSHUT), and a flag that suppresses the substrate clock (SUBCK). Two sources set the timing. One is the vertical sync pulse (VD). The other is the pair of edge strobes that a separate sync controller makes from an external SYNC signal.

During the SYNC interval the normal VD-timed register update is disabled. Each change therefore waits for its own event. Arming the exposure takes effect only at the next VD. A request to open the shutter waits for the SYNC falling edge, which stands in for a VD. A request to close the shutter waits for the SYNC rising edge, so the shutter's falling edge lines up with that edge. No exposure counter is involved: the host and the SYNC signal set how long the exposure lasts. A phase output lets the rest of the chip follow the sequence.

Top module: `shutter_seq`

## Requirements
- R1: After reset, `phase_o` is 0 (idle) and `vsub_o`, `mshut_o` and `subck_sup_o` are all low. The phase codes are idle 0, armed 1, exposing 2, readout 3 and done 4.
- R2: In idle, a write of action code 5 moves `phase_o` to armed on the next clock. `vsub_o` stays low in that phase.
- R3: In armed, a `vd_pulse` moves the phase to exposing on the next clock, and `vsub_o` rises on that same clock.
- R4: `subck_sup_o` and `vsub_o` are high exactly while the phase is exposing or readout, and low in every other phase.
- R5: A pending open request (`msh_val`=1) is applied at a `sync_fall` strobe that arrives while exposing. `mshut_o` goes high one clock after that strobe.
- R6: In exposing, a write of action code 6 moves the phase to readout on the next clock.
- R7: In readout, a `sync_rise` strobe moves the phase to done. On that same edge, a pending close request (`msh_val`=0) drives `mshut_o` low. Both outputs change one clock after the strobe.
- R8: In done, a `vd_pulse` returns the phase to idle on the next clock.
- R9: The phase does not change on action codes other than 5 or 6, on code 6 outside exposing, or on code 5 outside idle.
- R10: A shutter request stays pending until its qualifying edge arrives, and only that edge applies it. A later write before that edge replaces the pending value. An edge that does not qualify leaves `mshut_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| act_we | input | 1 | Action-code write strobe |
| act_code | input | ACT_W | Action-code value |
| msh_we | input | 1 | Shutter request write strobe |
| msh_val | input | 1 | Requested shutter state (1 open, 0 closed) |
| vd_pulse | input | 1 | One-clock VD pulse |
| sync_fall | input | 1 | One-clock strobe marking a SYNC falling edge |
| sync_rise | input | 1 | One-clock strobe marking a SYNC rising edge |
| vsub_o | output | 1 | Substrate pulse control |
| mshut_o | output | 1 | Mechanical shutter control |
| subck_sup_o | output | 1 | Substrate clock suppression |
| phase_o | output | 3 | Current sequence phase |

## Verification
The bench builds the block with its default parameters: a 3-bit action code, arm code 5 and readout code 6. With a 3-bit code, every value from 0 to 7 can be written in every phase, so the check that stray codes are ignored covers the whole code space. The sequences include shutter requests written in the wrong phase, requests replaced before their edge, and SYNC edges that arrive in the wrong phase. They also include a readout that ends with no close request pending, which leaves the shutter open into done.

// File: rtl/shseq_pkg.sv
package shseq_pkg;
    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_ARMED  = 3'd1,
        PH_EXPOSE = 3'd2,
        PH_READ   = 3'd3,
        PH_DONE   = 3'd4
    } phase_e;
endpackage

// File: rtl/shseq_phase.sv
module shseq_phase
    import shseq_pkg::*;
#(
    parameter int ACT_W     = 3,
    parameter int ARM_CODE  = 5,
    parameter int READ_CODE = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act_we,
    input  logic [ACT_W-1:0] act_code,
    input  logic             vd_pulse,
    input  logic             sync_rise,
    output phase_e           phase,
    output logic             vsub,
    output logic             subck_sup
);
    localparam logic [ACT_W-1:0] ARM_V  = ACT_W'(ARM_CODE);
    localparam logic [ACT_W-1:0] READ_V = ACT_W'(READ_CODE);

    typedef struct packed {
        phase_e ph;
        logic   vsub;
        logic   subck;
    } st_t;

    st_t st_d, st_q;
    logic active_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q.ph)
            PH_IDLE:   if (act_we && act_code == ARM_V)  st_d.ph = PH_ARMED;
            PH_ARMED:  if (vd_pulse)                     st_d.ph = PH_EXPOSE;
            PH_EXPOSE: if (act_we && act_code == READ_V) st_d.ph = PH_READ;
            PH_READ:   if (sync_rise)                    st_d.ph = PH_DONE;
            PH_DONE:   if (vd_pulse)                     st_d.ph = PH_IDLE;
            default:                                     st_d.ph = PH_IDLE;
        endcase
        active_d   = (st_d.ph == PH_EXPOSE) || (st_d.ph == PH_READ);
        st_d.vsub  = active_d;
        st_d.subck = active_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{ph: PH_IDLE, vsub: 1'b0, subck: 1'b0};
        else        st_q <= st_d;
    end

    assign phase     = st_q.ph;
    assign vsub      = st_q.vsub;
    assign subck_sup = st_q.subck;
endmodule

// File: rtl/shseq_mshut.sv
module shseq_mshut
    import shseq_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   msh_we,
    input  logic   msh_val,
    input  logic   sync_fall,
    input  logic   sync_rise,
    input  phase_e phase,
    output logic   mshut,
    output logic   pend_v,
    output logic   pend_val
);
    typedef struct packed {
        logic mshut;
        logic pv;
        logic pval;
    } req_t;

    req_t r_d, r_q;
    logic open_fire, close_fire;

    always_comb begin
        r_d        = r_q;
        open_fire  = r_q.pv && r_q.pval && sync_fall && (phase == PH_EXPOSE);
        close_fire = r_q.pv && !r_q.pval && sync_rise && (phase == PH_READ);
        if (open_fire || close_fire) begin
            r_d.mshut = r_q.pval;
            r_d.pv    = 1'b0;
        end
        if (msh_we) begin
            r_d.pv   = 1'b1;
            r_d.pval = msh_val;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign mshut    = r_q.mshut;
    assign pend_v   = r_q.pv;
    assign pend_val = r_q.pval;
endmodule

// File: rtl/shutter_seq.sv
module shutter_seq
    import shseq_pkg::*;
#(
    parameter int ACT_W     = 3,
    parameter int ARM_CODE  = 5,
    parameter int READ_CODE = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act_we,
    input  logic [ACT_W-1:0] act_code,
    input  logic             msh_we,
    input  logic             msh_val,
    input  logic             vd_pulse,
    input  logic             sync_fall,
    input  logic             sync_rise,
    output logic             vsub_o,
    output logic             mshut_o,
    output logic             subck_sup_o,
    output logic [2:0]       phase_o
);
    phase_e phase;
    logic   pend_v, pend_val;

    shseq_phase #(
        .ACT_W(ACT_W), .ARM_CODE(ARM_CODE), .READ_CODE(READ_CODE)
    ) u_phase (
        .clk(clk), .rst_n(rst_n), .act_we(act_we), .act_code(act_code),
        .vd_pulse(vd_pulse), .sync_rise(sync_rise),
        .phase(phase), .vsub(vsub_o), .subck_sup(subck_sup_o)
    );

    shseq_mshut u_mshut (
        .clk(clk), .rst_n(rst_n), .msh_we(msh_we), .msh_val(msh_val),
        .sync_fall(sync_fall), .sync_rise(sync_rise), .phase(phase),
        .mshut(mshut_o), .pend_v(pend_v), .pend_val(pend_val)
    );

    assign phase_o = phase;
endmodule

// File: rtl/shseq_chk.sv
module shseq_chk
    import shseq_pkg::*;
#(
    parameter int ACT_W     = 3,
    parameter int ARM_CODE  = 5,
    parameter int READ_CODE = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             act_we,
    input logic [ACT_W-1:0] act_code,
    input logic             msh_we,
    input logic             sync_fall,
    input logic             sync_rise,
    input logic             vd_pulse,
    input logic             vsub_o,
    input logic             mshut_o,
    input logic             subck_sup_o,
    input logic [2:0]       phase_o,
    input logic             pend_v,
    input logic             pend_val
);
    localparam logic [ACT_W-1:0] ARM_V  = ACT_W'(ARM_CODE);
    localparam logic [ACT_W-1:0] READ_V = ACT_W'(READ_CODE);

    p_arm_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == PH_IDLE && act_we && act_code == ARM_V) |=> (phase_o == PH_ARMED && !vsub_o));

    p_vsub_on_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == PH_ARMED && vd_pulse) |=> (phase_o == PH_EXPOSE && vsub_o));

    p_subck_phase_r4: assert property (@(posedge clk) disable iff (!rst_n)
        subck_sup_o == (phase_o == PH_EXPOSE || phase_o == PH_READ));

    p_open_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == PH_EXPOSE && sync_fall && pend_v && pend_val) |=> mshut_o);

    p_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == PH_EXPOSE && act_we && act_code == READ_V) |=> (phase_o == PH_READ));

    p_close_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == PH_READ && sync_rise && pend_v && !pend_val) |=> (!mshut_o && phase_o == PH_DONE));

    p_back_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == PH_DONE && vd_pulse) |=> (phase_o == PH_IDLE));

    p_stray_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (act_we && act_code != ARM_V && act_code != READ_V && !vd_pulse && !sync_rise)
        |=> $stable(phase_o));

    p_hold_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!msh_we && !sync_fall && !sync_rise) |=> ($stable(pend_v) && $stable(mshut_o)));
endmodule

bind shutter_seq shseq_chk #(
    .ACT_W(ACT_W), .ARM_CODE(ARM_CODE), .READ_CODE(READ_CODE)
) u_chk (.*);

// File: tb/shutter_seq_tb.sv
module shutter_seq_tb;
    localparam int ACT_W = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic act_we = 1'b0, msh_we = 1'b0, msh_val = 1'b0;
    logic [ACT_W-1:0] act_code = '0;
    logic vd_pulse = 1'b0, sync_fall = 1'b0, sync_rise = 1'b0;
    logic vsub_o, mshut_o, subck_sup_o;
    logic [2:0] phase_o;

    int total = 0, bad = 0, cycles = 0;
    bit finished = 0;
    string cur = "R1";

    // reference model state
    int m_ph = 0, m_vsub = 0, m_msh = 0, m_pv = 0, m_pval = 0;

    always #2.5 clk = ~clk;

    shutter_seq u_dut (
        .clk(clk), .rst_n(rst_n), .act_we(act_we), .act_code(act_code),
        .msh_we(msh_we), .msh_val(msh_val), .vd_pulse(vd_pulse),
        .sync_fall(sync_fall), .sync_rise(sync_rise),
        .vsub_o(vsub_o), .mshut_o(mshut_o), .subck_sup_o(subck_sup_o),
        .phase_o(phase_o)
    );

    always @(posedge clk) begin
        int nph, nmsh, npv, npval;
        if (!rst_n) begin
            m_ph = 0; m_vsub = 0; m_msh = 0; m_pv = 0; m_pval = 0;
        end else begin
            nph = m_ph; nmsh = m_msh; npv = m_pv; npval = m_pval;
            if (m_ph == 0 && act_we && act_code == 5) nph = 1;
            if (m_ph == 1 && vd_pulse) nph = 2;
            if (m_ph == 2 && act_we && act_code == 6) nph = 3;
            if (m_ph == 3 && sync_rise) nph = 4;
            if (m_ph == 4 && vd_pulse) nph = 0;
            if (m_pv == 1 && m_pval == 1 && sync_fall && m_ph == 2) begin nmsh = 1; npv = 0; end
            if (m_pv == 1 && m_pval == 0 && sync_rise && m_ph == 3) begin nmsh = 0; npv = 0; end
            if (msh_we) begin npv = 1; npval = int'(msh_val); end
            m_ph = nph; m_msh = nmsh; m_pv = npv; m_pval = npval;
            m_vsub = (nph == 2 || nph == 3) ? 1 : 0;
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            total++;
            if (int'(phase_o) != m_ph || int'(vsub_o) != m_vsub ||
                int'(subck_sup_o) != m_vsub || int'(mshut_o) != m_msh) begin
                bad++;
                $display("FAIL %s: phase/vsub/subck/mshut actual=%0d/%0d/%0d/%0d expected=%0d/%0d/%0d/%0d",
                         cur, phase_o, vsub_o, subck_sup_o, mshut_o, m_ph, m_vsub, m_vsub, m_msh);
            end
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000 && !finished) begin
            bad++;
            $display("FAIL watchdog: actual=%0d cycles expected<=5000", cycles);
            finish_run();
        end
    end

    // one stimulus cycle: inputs set after an edge, consumed by the next, then cleared
    task automatic cyc(input logic we, input logic [ACT_W-1:0] code, input logic mwe,
                       input logic mval, input logic vd, input logic sf, input logic sr);
        @(posedge clk); #1;
        act_we = we; act_code = code; msh_we = mwe; msh_val = mval;
        vd_pulse = vd; sync_fall = sf; sync_rise = sr;
        @(posedge clk); #1;
        act_we = 0; act_code = '0; msh_we = 0; msh_val = 0;
        vd_pulse = 0; sync_fall = 0; sync_rise = 0;
    endtask

    task automatic expect_out(input string tag, input int ph, input int vs, input int ms);
        total++;
        if (int'(phase_o) != ph || int'(vsub_o) != vs || int'(subck_sup_o) != vs ||
            int'(mshut_o) != ms) begin
            bad++;
            $display("FAIL %s: phase/vsub/subck/mshut actual=%0d/%0d/%0d/%0d expected=%0d/%0d/%0d/%0d",
                     tag, phase_o, vsub_o, subck_sup_o, mshut_o, ph, vs, vs, ms);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1; rst_n = 1;
        cur = "R1"; expect_out("R1 reset", 0, 0, 0);

        cur = "R9";
        for (int c = 0; c < 8; c++)
            if (c != 5) begin
                cyc(1, ACT_W'(c), 0, 0, 0, 0, 0);
                expect_out("R9 stray code in idle", 0, 0, 0);
            end

        cur = "R2";
        cyc(1, 3'd5, 0, 0, 0, 0, 0);
        expect_out("R2 arm", 1, 0, 0);
        cur = "R9";
        cyc(1, 3'd6, 0, 0, 0, 0, 0);
        expect_out("R9 code 6 while armed", 1, 0, 0);
        cyc(1, 3'd5, 0, 0, 0, 0, 0);
        expect_out("R9 code 5 while armed", 1, 0, 0);

        cur = "R10";
        cyc(0, 0, 1, 1, 0, 0, 0);
        cyc(0, 0, 0, 0, 0, 1, 0);
        expect_out("R10 sync fall while armed not applied", 1, 0, 0);

        cur = "R3";
        cyc(0, 0, 0, 0, 1, 0, 0);
        expect_out("R3 vsub on at vd", 2, 1, 0);
        cur = "R4";
        expect_out("R4 subck suppressed while exposing", 2, 1, 0);

        cur = "R10";
        cyc(0, 0, 1, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0, 1, 0);
        expect_out("R10 pending close ignores sync fall", 2, 1, 0);
        cyc(0, 0, 1, 1, 0, 0, 0);
        cyc(0, 0, 0, 0, 0, 0, 1);
        expect_out("R10 open ignores sync rise", 2, 1, 0);
        cyc(1, 3'd5, 0, 0, 0, 0, 0);
        expect_out("R9 code 5 while exposing", 2, 1, 0);

        cur = "R5";
        cyc(0, 0, 0, 0, 0, 1, 0);
        expect_out("R5 open at sync fall", 2, 1, 1);

        cur = "R6";
        cyc(0, 0, 1, 0, 0, 0, 0);
        cyc(1, 3'd6, 0, 0, 0, 0, 0);
        expect_out("R6 readout start", 3, 1, 1);
        cur = "R8";
        cyc(0, 0, 0, 0, 1, 0, 0);
        expect_out("R8 vd in readout no change", 3, 1, 1);

        cur = "R7";
        cyc(0, 0, 0, 0, 0, 0, 1);
        expect_out("R7 close at sync rise", 4, 0, 0);
        cur = "R4";
        expect_out("R4 subck released in done", 4, 0, 0);

        cur = "R8";
        cyc(0, 0, 0, 0, 1, 0, 0);
        expect_out("R8 back to idle", 0, 0, 0);

        // second run: no close pending at readout end
        cur = "R7";
        cyc(1, 3'd5, 0, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 1, 0, 0);
        cyc(0, 0, 1, 1, 0, 0, 0);
        cyc(0, 0, 0, 0, 0, 1, 0);
        expect_out("R5 open on second run", 2, 1, 1);
        cyc(1, 3'd6, 0, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0, 0, 1);
        expect_out("R7 done with shutter left open", 4, 0, 1);
        cur = "R8";
        cyc(0, 0, 0, 0, 1, 0, 0);
        expect_out("R8 idle after second run", 0, 0, 1);

        cur = "R1";
        @(posedge clk); #1; rst_n = 0;
        @(posedge clk); #1; rst_n = 1;
        expect_out("R1 reset again", 0, 0, 0);

        repeat (2) @(posedge clk);
        finish_run();
    end
endmodule